// File: doc/BRIEF.md
# Handshaked Multichannel I/Q Output Port

This block collects complex samples from six upstream channel sources and sends them out over one 16-bit bus to a downstream receiver. Each source presents a 16-bit in-phase word, a 16-bit quadrature word, a gain word and a one-cycle valid strobe. The block stores the latest sample of each enabled source in its own slot. It serves pending slots in ascending channel order. Each word it sends is tagged with side-band flags: the channel number, an I/Q phase flag and a gain-word flag.

The transfer uses a request/acknowledge handshake, and everything runs on one port clock. The port raises `req`, spends one cycle in a request phase, and then presents one word per cycle. Any cycle in which `ack` is low freezes the port. Two format options are set by static inputs. The first selects full-width interleaved I/Q words or byte-packed I/Q words, where the upper byte of each of I and Q goes into one bus word. The second appends the gain word after each sample. These inputs are expected to change only while the port is idle.

Top module: `iq_out_port`

## Requirements
- R1: After reset, and whenever no enabled sample is pending, `req`, `iq_flag` and `gain_flag` are low and `dout` and `ch_id` are zero. `dout` is zero in every cycle where `req` is low.
- R2: A sample strobed on a channel whose bit in `ch_en` is 0 is ignored. It is never sent, and `req` stays low if nothing else is pending.
- R3: Once an enabled sample is pending, `req` rises. While `req` is high and no word is on the bus, the bus reads zero with all flags low (request phase). The first word of the sample appears at the first rising edge at which `ack` is high during that phase.
- R4: With `fmt_packed`=0, the 16-bit I word is shown with `iq_flag`=1. It is followed in the next accepted cycle by the 16-bit Q word with `iq_flag`=0.
- R5: With `gain_app`=1, the gain word follows the last data word of each sample, in either format. `gain_flag` is 1 only in that cycle, with `iq_flag`=0. An interleaved sample therefore takes 3 accepted cycles without the gain word and 4 with it.
- R6: With `fmt_packed`=1, one word carries I[15:8] in `dout[15:8]` and Q[15:8] in `dout[7:0]`, with `iq_flag`=1.
- R7: In packed format, the next pending channel follows directly with no request phase between them. `iq_flag` stays high across back-to-back channels until none is pending, unless a gain word intervenes.
- R8: While any word of a sample is on the bus, `ch_id` holds the binary number (0 to 5) of its source channel.
- R9: In a cycle where `req` is high and `ack` is low, the next cycle keeps `req` high and leaves `dout`, `ch_id`, `iq_flag` and `gain_flag` unchanged.
- R10: When several enabled channels are pending, the lowest channel number is sent first.
- R11: A sample strobed on a channel in the same cycle its previous sample is taken onto the bus is kept and sent afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_packed | input | 1 | 0: interleaved 16-bit I/Q, 1: byte-packed I/Q |
| gain_app | input | 1 | Append gain word after each sample |
| ch_en | input | 6 | Per-channel enable mask, bit k for channel k |
| src_i | input | 96 | I words, channel k in bits [16k+15:16k] |
| src_q | input | 96 | Q words, same layout |
| src_gain | input | 96 | Gain words, same layout |
| src_vld | input | 6 | Per-channel sample strobe |
| ack | input | 1 | Receiver ready |
| req | output | 1 | Port has data to send |
| dout | output | 16 | Output data word |
| ch_id | output | 3 | Source channel of the current word |
| iq_flag | output | 1 | High on I word / packed word |
| gain_flag | output | 1 | High on gain word |

## Verification
The sharpest overlap is a fresh strobe on a channel arriving in the very cycle its stored sample leaves the slot. The capture and the release then both act on the same pending bit. The bench provokes it directly: it re-strobes the channel with new data exactly one cycle after `req` rises, with `ack` held high. It then expects both the old sample and the new one in order, in both formats. A second overlap, the release of one channel while the arbiter already picks the next, is judged by the unbroken packed word stream and by the ascending channel order.

// File: rtl/iq_port_pkg.sv
package iq_port_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_REQ   = 3'd1,
    PH_IWORD = 3'd2,
    PH_QWORD = 3'd3,
    PH_GWORD = 3'd4,
    PH_PACK  = 3'd5
  } phase_e;
endpackage

// File: rtl/iq_chan_slot.sv
module iq_chan_slot #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          take,
  input  logic [DW-1:0] din_i,
  input  logic [DW-1:0] din_q,
  input  logic [DW-1:0] din_g,
  output logic          pend,
  output logic [DW-1:0] hold_i,
  output logic [DW-1:0] hold_q,
  output logic [DW-1:0] hold_g
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      hold_i <= '0;
      hold_q <= '0;
      hold_g <= '0;
    end else if (accept) begin
      pend   <= 1'b1;
      hold_i <= din_i;
      hold_q <= din_q;
      hold_g <= din_g;
    end else if (take) begin
      pend   <= 1'b0;
    end
  end

  // R11: a fresh sample landing on the release cycle survives
  a_r11_new_kept: assert property (@(posedge clk) disable iff (!rst_n)
    accept && take |=> pend);
  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    take && !accept |=> !pend);
endmodule

// File: rtl/iq_pick.sv
module iq_pick #(
  parameter int NCH = 6,
  parameter int CHW = 3
) (
  input  logic [NCH-1:0] ready,
  output logic           any,
  output logic [CHW-1:0] sel
);
  function automatic logic [CHW-1:0] lowest_set(input logic [NCH-1:0] v);
    logic [CHW-1:0] idx;
    idx = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (v[k]) idx = CHW'(k);
    end
    return idx;
  endfunction

  always_comb begin
    any = |ready;
    sel = lowest_set(ready);
  end
endmodule

// File: rtl/iq_seq.sv
module iq_seq
  import iq_port_pkg::*;
#(
  parameter int DW  = 16,
  parameter int CHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ack,
  input  logic           fmt_packed,
  input  logic           gain_app,
  input  logic           any,
  input  logic [CHW-1:0] sel,
  input  logic [DW-1:0]  sel_i,
  input  logic [DW-1:0]  sel_q,
  input  logic [DW-1:0]  sel_g,
  output logic           take_en,
  output logic           req,
  output logic [DW-1:0]  dout,
  output logic [CHW-1:0] ch_id,
  output logic           iq_flag,
  output logic           gain_flag
);
  localparam int HB = DW / 2;

  function automatic logic [DW-1:0] pack_upper(input logic [DW-1:0] i_w,
                                                input logic [DW-1:0] q_w);
    return {i_w[DW-1 -: HB], q_w[DW-1 -: HB]};
  endfunction

  phase_e         ph, ph_n;
  logic [DW-1:0]  q_sh, g_sh, q_sh_n, g_sh_n, dout_n;
  logic [CHW-1:0] ch_n;
  logic           iq_n, gn_n;
  logic           last_word;   // final word of a sample accepted this cycle
  logic           load_word;   // a new sample is put on the bus this cycle

  always_comb begin
    last_word = ack && ((ph == PH_GWORD) ||
                        (!gain_app && (ph == PH_QWORD || ph == PH_PACK)));
    load_word = any && ((ph == PH_REQ && ack) || (last_word && fmt_packed));
    take_en   = load_word;
  end

  always_comb begin
    ph_n   = ph;
    dout_n = dout;
    ch_n   = ch_id;
    iq_n   = iq_flag;
    gn_n   = gain_flag;
    q_sh_n = q_sh;
    g_sh_n = g_sh;
    if (load_word) begin
      ph_n   = fmt_packed ? PH_PACK : PH_IWORD;
      dout_n = fmt_packed ? pack_upper(sel_i, sel_q) : sel_i;
      ch_n   = sel;
      iq_n   = 1'b1;
      gn_n   = 1'b0;
      q_sh_n = sel_q;
      g_sh_n = sel_g;
    end else if (last_word || (ph == PH_REQ && ack)) begin
      ph_n   = (any && !fmt_packed) ? PH_REQ : PH_IDLE;
      dout_n = '0;
      ch_n   = '0;
      iq_n   = 1'b0;
      gn_n   = 1'b0;
    end else if (ack) begin
      case (ph)
        PH_IDLE: if (any) ph_n = PH_REQ;
        PH_IWORD: begin
          ph_n   = PH_QWORD;
          dout_n = q_sh;
          iq_n   = 1'b0;
        end
        PH_QWORD, PH_PACK: begin
          ph_n   = PH_GWORD;
          dout_n = g_sh;
          iq_n   = 1'b0;
          gn_n   = 1'b1;
        end
        default: ph_n = ph;
      endcase
    end else if (ph == PH_IDLE && any) begin
      ph_n = PH_REQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      dout      <= '0;
      ch_id     <= '0;
      iq_flag   <= 1'b0;
      gain_flag <= 1'b0;
      q_sh      <= '0;
      g_sh      <= '0;
    end else begin
      ph        <= ph_n;
      dout      <= dout_n;
      ch_id     <= ch_n;
      iq_flag   <= iq_n;
      gain_flag <= gn_n;
      q_sh      <= q_sh_n;
      g_sh      <= g_sh_n;
    end
  end

  assign req = (ph != PH_IDLE);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (dout == '0) && !iq_flag && !gain_flag);
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack |=> req && $stable(dout) && $stable(ch_id)
                    && $stable(iq_flag) && $stable(gain_flag));
  a_r3_first_word: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_REQ) && ack && any |=> iq_flag);
  a_r4_q_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IWORD) && ack |=> req && !iq_flag && !gain_flag);
  a_r5_gain_after: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_QWORD) || (ph == PH_PACK)) && ack && gain_app |=> gain_flag);
  a_r5_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(gain_flag && iq_flag));
  a_r7_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_PACK) && ack && !gain_app && any && fmt_packed |=> iq_flag);
endmodule

// File: rtl/iq_out_port.sv
module iq_out_port #(
  parameter int NCH = 6,
  parameter int DW  = 16,
  parameter int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt_packed,
  input  logic              gain_app,
  input  logic [NCH-1:0]    ch_en,
  input  logic [NCH*DW-1:0] src_i,
  input  logic [NCH*DW-1:0] src_q,
  input  logic [NCH*DW-1:0] src_gain,
  input  logic [NCH-1:0]    src_vld,
  input  logic              ack,
  output logic              req,
  output logic [DW-1:0]     dout,
  output logic [CHW-1:0]    ch_id,
  output logic              iq_flag,
  output logic              gain_flag
);
  logic [NCH-1:0]    pend_v, ready_v, take_v;
  logic [NCH*DW-1:0] hi_v, hq_v, hg_v;
  logic              any, take_en;
  logic [CHW-1:0]    sel;
  logic [DW-1:0]     sel_i, sel_q, sel_g;

  for (genvar k = 0; k < NCH; k++) begin : g_slot
    assign take_v[k] = take_en && (sel == CHW'(k));
    iq_chan_slot #(.DW(DW)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (src_vld[k] && ch_en[k]),
      .take   (take_v[k]),
      .din_i  (src_i[k*DW +: DW]),
      .din_q  (src_q[k*DW +: DW]),
      .din_g  (src_gain[k*DW +: DW]),
      .pend   (pend_v[k]),
      .hold_i (hi_v[k*DW +: DW]),
      .hold_q (hq_v[k*DW +: DW]),
      .hold_g (hg_v[k*DW +: DW])
    );
  end

  assign ready_v = pend_v & ch_en;

  iq_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
    .ready (ready_v),
    .any   (any),
    .sel   (sel)
  );

  always_comb begin
    sel_i = '0;
    sel_q = '0;
    sel_g = '0;
    for (int k = 0; k < NCH; k++) begin
      if (sel == CHW'(k)) begin
        sel_i = hi_v[k*DW +: DW];
        sel_q = hq_v[k*DW +: DW];
        sel_g = hg_v[k*DW +: DW];
      end
    end
  end

  iq_seq #(.DW(DW), .CHW(CHW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack        (ack),
    .fmt_packed (fmt_packed),
    .gain_app   (gain_app),
    .any        (any),
    .sel        (sel),
    .sel_i      (sel_i),
    .sel_q      (sel_q),
    .sel_g      (sel_g),
    .take_en    (take_en),
    .req        (req),
    .dout       (dout),
    .ch_id      (ch_id),
    .iq_flag    (iq_flag),
    .gain_flag  (gain_flag)
  );

  a_r2_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    (take_v & ~ch_en) == '0);
  a_r10_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    take_en |-> ready_v[sel] && ((ready_v & ((NCH'(1) << sel) - NCH'(1))) == '0));
  a_r8_single_take: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_v));
  a_r8_id_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ch_id) < NCH);
endmodule

// File: tb/iq_out_port_test.sv
module iq_out_port_test;
  localparam int NCH = 6;
  localparam int DW  = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic fmt_packed, gain_app, ack;
  logic [NCH-1:0] ch_en, src_vld;
  logic [NCH*DW-1:0] src_i, src_q, src_gain;
  logic req, iq_flag, gain_flag;
  logic [DW-1:0] dout;
  logic [2:0] ch_id;

  logic [15:0] bi [NCH];
  logic [15:0] bq [NCH];
  logic [15:0] bg [NCH];

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] e_d [64];
  logic [2:0]  e_c [64];
  logic        e_iq [64];
  logic        e_g [64];
  int n_exp;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      src_i[k*DW +: DW]    = bi[k];
      src_q[k*DW +: DW]    = bq[k];
      src_gain[k*DW +: DW] = bg[k];
    end
  end

  iq_out_port uut (
    .clk(clk), .rst_n(rst_n), .fmt_packed(fmt_packed), .gain_app(gain_app),
    .ch_en(ch_en), .src_i(src_i), .src_q(src_q), .src_gain(src_gain),
    .src_vld(src_vld), .ack(ack), .req(req), .dout(dout), .ch_id(ch_id),
    .iq_flag(iq_flag), .gain_flag(gain_flag)
  );

  function automatic logic [15:0] bytes_of(input logic [15:0] i_w, input logic [15:0] q_w);
    return (i_w & 16'hFF00) | (q_w >> 8);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] d, input logic [2:0] c, input logic q, input logic g);
    e_d[n_exp] = d; e_c[n_exp] = c; e_iq[n_exp] = q; e_g[n_exp] = g;
    n_exp++;
  endtask

  task automatic push_sample(input int c, input logic [15:0] vi, input logic [15:0] vq,
                             input logic [15:0] vg, input bit first);
    if (!fmt_packed || first) push(16'h0, 3'd0, 1'b0, 1'b0);    // R3 request phase
    if (fmt_packed) push(bytes_of(vi, vq), 3'(c), 1'b1, 1'b0);   // R6
    else begin
      push(vi, 3'(c), 1'b1, 1'b0);                               // R4
      push(vq, 3'(c), 1'b0, 1'b0);
    end
    if (gain_app) push(vg, 3'(c), 1'b0, 1'b1);                   // R5
  endtask

  // vmask: channels strobed; col_ch >= 0 re-strobes that channel as its first sample is taken
  task automatic run_case(input string name, input logic [5:0] vmask, input logic [5:0] en,
                          input bit pk, input bit gn, input int stall, input int col_ch);
    logic [15:0] ni, nq, ng;
    logic [15:0] hd; logic [2:0] hc; logic hiq, hg; bit hold_pend;
    int idx;
    bit first;
    fmt_packed = pk; gain_app = gn; ch_en = en;
    for (int k = 0; k < NCH; k++) begin
      bi[k] = 16'($urandom); bq[k] = 16'($urandom); bg[k] = 16'($urandom);
    end
    ni = 16'($urandom); nq = 16'($urandom); ng = 16'($urandom);
    n_exp = 0; first = 1;
    for (int k = 0; k < NCH; k++) begin                          // R10 ascending
      if (vmask[k] && en[k]) begin
        push_sample(k, bi[k], bq[k], bg[k], first);
        first = 0;
      end
    end
    if (col_ch >= 0) push_sample(col_ch, ni, nq, ng, 0);         // R11
    idx = 0; hold_pend = 0;
    for (int it = 0; it < 2000; it++) begin
      @(negedge clk);
      src_vld = '0;
      if (it == 0) src_vld = vmask;
      if (it == 2 && col_ch >= 0) begin
        bi[col_ch] = ni; bq[col_ch] = nq; bg[col_ch] = ng;
        src_vld[col_ch] = 1'b1;
      end
      if (hold_pend) begin                                       // R9
        check({name, " R9 hold"}, {req, hd, 1'b0, hc, 2'b0, hiq, hg},
              {1'b1, dout, 1'b0, ch_id, 2'b0, iq_flag, gain_flag});
        hold_pend = 0;
      end
      ack = ((it > 1) && (int'($urandom % 100) < stall)) ? 1'b0 : 1'b1;
      if (req && !ack) begin
        hd = dout; hc = ch_id; hiq = iq_flag; hg = gain_flag; hold_pend = 1;
      end
      if (req && ack && idx < n_exp) begin                       // R8 channel tag
        check({name, " R3-R8 word"}, {dout, 1'b0, ch_id, 2'b0, iq_flag, gain_flag},
              {e_d[idx], 1'b0, e_c[idx], 2'b0, e_iq[idx], e_g[idx]});
        idx++;
      end
      if (it >= 6 && idx >= n_exp) break;
    end
    check({name, " R10 all words seen"}, 32'(idx), 32'(n_exp));
    ack = 1'b1;
    repeat (4) @(negedge clk);
    // R1 / R2: nothing left, ignored channels never raise a request
    check({name, " R1 R2 quiet"}, {req, dout, iq_flag, gain_flag}, 32'h0);
  endtask

  initial begin
    int w;
    for (w = 0; w < 150000 && !done; w++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; ack = 1'b1; fmt_packed = 1'b0; gain_app = 1'b0;
    ch_en = '0; src_vld = '0;
    for (int k = 0; k < NCH; k++) begin bi[k] = '0; bq[k] = '0; bg[k] = '0; end
    repeat (3) @(negedge clk);
    check("R1 reset", {req, dout, 1'b0, ch_id, iq_flag, gain_flag}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {req, dout, iq_flag, gain_flag}, 32'h0);

    run_case("single interleaved", 6'b001000, 6'h3F, 0, 0, 0, -1);
    run_case("interleaved gain", 6'b100001, 6'h3F, 0, 1, 40, -1);
    run_case("packed burst", 6'b010110, 6'h3F, 1, 0, 30, -1);
    run_case("packed gain masked", 6'h3F, 6'b110111, 1, 1, 25, -1);
    run_case("disabled only R2", 6'b000100, 6'b111011, 0, 0, 0, -1);
    run_case("collision interleaved R11", 6'b000100, 6'h3F, 0, 1, 0, 2);
    run_case("collision packed R11", 6'b100000, 6'h3F, 1, 0, 0, 5);
    run_case("all interleaved R10", 6'h3F, 6'h3F, 0, 0, 50, -1);
    for (int r = 0; r < 20; r++) begin
      run_case("random", 6'($urandom), 6'($urandom), 1'($urandom), 1'($urandom),
               int'($urandom % 60), -1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule